// File: doc/BRIEF.md
# Eight-Channel PWM Timer

This block is a bank of pulse-width-modulation timers behind a simple word-wide register port. Each of its eight channels owns a counter, a duty threshold, a period limit and a control word. While a channel runs, its counter steps once per count tick and returns to zero at the end of every period. The output pin sits at its active (low) level for the first part of the period and goes high for the rest. Each period end sets a pending flag, and that flag can raise an interrupt line for the channel.

Count ticks come from the system clock or from an external clock input. The external clock passes through a synchroniser, and ticks are taken on its rising or its falling edge. A channel can run freely or stop after one period. Software can load the counter directly at any time, or clear it through a self-clearing control bit. The channels sit in two banks of four, and the two banks are selected by the top address bit.

Top module: `pwm_tmr_top`

## Requirements
- R1: Addressing uses a byte address. Channel n (0..3) sits at n*0x10 and channel n (4..7) at 0x8000 + (n-4)*0x10. Inside a channel, 0x0 is the counter, 0x4 the duty threshold, 0x8 the period limit and 0xC the control word. An address with nonzero bits [1:0] or [14:6] hits nothing: a write to it changes nothing, and a read returns 0. Read data appears on busRdata with busRvalid high one cycle after the request.
- R2: Control word bits, all readable: bit0 run, bit1 external tick select, bit2 falling-edge select, bit3 pin drive enable, bit4 single-period, bit5 interrupt enable, bit8 capture enable (storage only). A write stores all of these.
- R3: While running on the system clock with period limit L > 0, the counter rises by one per cycle and goes from L-1 to 0, so the period is L cycles. With L = 0 the counter stays at 0.
- R4: pwmOut[n] is 0 while the counter is below the duty threshold H and 1 otherwise. When H >= L the output stays 0 for the whole period.
- R5: pwmOe[n] follows control bit3. Clearing run and bit3 stops the channel and releases the pin.
- R6: While run is clear, the counter keeps its value unless software writes it.
- R7: A write to the counter takes effect at that clock edge and overrides counting.
- R8: Each return to zero sets pending (bit6). Writing 1 to bit6 clears it, and writing 0 leaves it set. irq[n] is high exactly when pending and bit5 are both set.
- R9: In single-period mode the channel clears run at its first return to zero, and the counter then holds at 0.
- R10: Writing bit7 = 1 zeroes the counter on the following clock edge. Bit7 then reads back as 0.
- R11: With external ticks selected, the counter advances once per synchronised rising edge of extClk, or once per falling edge when bit2 is set. No other transition of extClk advances it.
- R12: Writes to one channel leave every other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access request, one cycle each |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| busRvalid | output | 1 | Read data valid, one cycle after a read request |
| extClk | input | 1 | Asynchronous external tick source |
| pwmOut | output | 8 | Per-channel PWM level |
| pwmOe | output | 8 | Per-channel pin drive enable |
| irq | output | 8 | Per-channel interrupt |

## Verification
The assertions assume that extClk holds each level for at least two system clocks, so that the three-flop edge detector sees every transition once. They also assume that bus requests are single-cycle pulses and that software never writes the counter and the clear bit to the same channel in one cycle. The bench holds each external clock phase for four cycles and issues one request at a time, with the strobe dropped after each edge. It leaves idle cycles after a clear before it reads back the result.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int BANKS = 2;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_HIGH  = 2'd1,
    REG_LOW   = 2'd2,
    REG_CTRL  = 2'd3
  } regSel_e;

  localparam int B_RUN   = 0;
  localparam int B_EXT   = 1;
  localparam int B_FALL  = 2;
  localparam int B_DRIVE = 3;
  localparam int B_ONCE  = 4;
  localparam int B_IRQEN = 5;
  localparam int B_PEND  = 6;
  localparam int B_CLR   = 7;
  localparam int B_CAPT  = 8;

  // strobes from the control/decode section to one channel datapath
  typedef struct packed {
    logic wrCount;
    logic wrHigh;
    logic wrLow;
    logic wrCtrl;
    logic extRise;
    logic extFall;
  } chanStb_t;
endpackage

// File: rtl/pwm_tmr_ctrl.sv
module pwm_tmr_ctrl
  import pwm_tmr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CH_PER_BANK = 4,
  parameter int NUM_CH      = BANKS * CH_PER_BANK
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busValid,
  input  logic                           busWrite,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           extClk,
  input  logic [NUM_CH-1:0][REG_W-1:0]   chCount,
  input  logic [NUM_CH-1:0][REG_W-1:0]   chHigh,
  input  logic [NUM_CH-1:0][REG_W-1:0]   chLow,
  input  logic [NUM_CH-1:0][REG_W-1:0]   chCtrl,
  output chanStb_t                       chStb [NUM_CH],
  output logic [REG_W-1:0]               busRdata,
  output logic                           busRvalid
);
  localparam int CSEL_W  = $clog2(CH_PER_BANK);
  localparam int CH_W    = CSEL_W + 1;
  localparam int HOLE_LO = 4 + CSEL_W;
  localparam int HOLE_HI = ADDR_W - 2;

  logic            hit;
  logic [CH_W-1:0] chIdx;
  regSel_e         regSel;
  logic [2:0]      extSync;
  logic            extRise, extFall;
  logic [REG_W-1:0] rdMux;

  assign hit    = busValid && (busAddr[1:0] == 2'b00) && (busAddr[HOLE_HI:HOLE_LO] == '0);
  assign chIdx  = {busAddr[ADDR_W-1], busAddr[4 +: CSEL_W]};
  assign regSel = regSel_e'(busAddr[3:2]);

  // two-flop synchroniser plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) extSync <= '0;
    else       extSync <= {extSync[1:0], extClk};
  end
  assign extRise = extSync[1] && !extSync[2];
  assign extFall = !extSync[1] && extSync[2];

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      chStb[c].wrCount = hit && busWrite && (chIdx == CH_W'(c)) && (regSel == REG_COUNT);
      chStb[c].wrHigh  = hit && busWrite && (chIdx == CH_W'(c)) && (regSel == REG_HIGH);
      chStb[c].wrLow   = hit && busWrite && (chIdx == CH_W'(c)) && (regSel == REG_LOW);
      chStb[c].wrCtrl  = hit && busWrite && (chIdx == CH_W'(c)) && (regSel == REG_CTRL);
      chStb[c].extRise = extRise;
      chStb[c].extFall = extFall;
    end
  end

  always_comb begin
    case (regSel)
      REG_COUNT: rdMux = chCount[chIdx];
      REG_HIGH:  rdMux = chHigh[chIdx];
      REG_LOW:   rdMux = chLow[chIdx];
      default:   rdMux = chCtrl[chIdx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRvalid <= 1'b0;
      busRdata  <= '0;
    end else begin
      busRvalid <= busValid && !busWrite;
      busRdata  <= (hit && !busWrite) ? rdMux : '0;
    end
  end

  assert_rvalid_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> busRvalid);
  assert_no_spurious_rvalid_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |=> !busRvalid);
  assert_misaligned_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr[1:0] != 2'b00) |=> (busRdata == '0));
endmodule

// File: rtl/pwm_tmr_chan.sv
module pwm_tmr_chan
  import pwm_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chanStb_t         stb,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] countVal,
  output logic [REG_W-1:0] highVal,
  output logic [REG_W-1:0] lowVal,
  output logic [REG_W-1:0] ctrlVal,
  output logic             pwmOut,
  output logic             pwmOe,
  output logic             irq
);
  logic [REG_W-1:0] cntQ, highQ, lowQ, cntNxt;
  logic runQ, extQ, fallQ, driveQ, onceQ, irqEnQ, pendQ, clrQ, captQ;
  logic tick, wrap;

  assign cntNxt = cntQ + 1'b1;
  assign tick   = runQ && (!extQ || (fallQ ? stb.extFall : stb.extRise));
  assign wrap   = tick && (cntNxt >= lowQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0; highQ <= '0; lowQ <= '0;
      runQ <= 1'b0; extQ <= 1'b0; fallQ <= 1'b0; driveQ <= 1'b0;
      onceQ <= 1'b0; irqEnQ <= 1'b0; pendQ <= 1'b0; clrQ <= 1'b0; captQ <= 1'b0;
    end else begin
      if (stb.wrCount)  cntQ <= wdata;
      else if (clrQ)    cntQ <= '0;
      else if (tick)    cntQ <= wrap ? '0 : cntNxt;

      if (stb.wrHigh) highQ <= wdata;
      if (stb.wrLow)  lowQ  <= wdata;

      clrQ <= stb.wrCtrl && wdata[B_CLR];

      if (stb.wrCtrl) begin
        runQ   <= wdata[B_RUN];
        extQ   <= wdata[B_EXT];
        fallQ  <= wdata[B_FALL];
        driveQ <= wdata[B_DRIVE];
        onceQ  <= wdata[B_ONCE];
        irqEnQ <= wdata[B_IRQEN];
        captQ  <= wdata[B_CAPT];
      end else if (wrap && onceQ) begin
        runQ <= 1'b0;
      end

      if (wrap)                              pendQ <= 1'b1;
      else if (stb.wrCtrl && wdata[B_PEND])  pendQ <= 1'b0;
    end
  end

  assign countVal = cntQ;
  assign highVal  = highQ;
  assign lowVal   = lowQ;
  assign ctrlVal  = {{(REG_W-9){1'b0}}, captQ, clrQ, pendQ, irqEnQ, onceQ,
                     driveQ, fallQ, extQ, runQ};
  assign pwmOut   = (cntQ >= highQ);
  assign pwmOe    = driveQ;
  assign irq      = pendQ && irqEnQ;

  assert_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !wrap && !stb.wrCount && !clrQ) |=> (cntQ == $past(cntQ) + 1'b1));
  assert_stopped_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !stb.wrCount && !clrQ) |=> $stable(cntQ));
  assert_wrap_pend_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> pendQ);
  assert_once_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrap && onceQ && !stb.wrCtrl && !stb.wrCount) |=> (!runQ && cntQ == '0));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clrQ && !stb.wrCount && !stb.wrCtrl) |=> (cntQ == '0 && !clrQ));
endmodule

// File: rtl/pwm_tmr_top.sv
module pwm_tmr_top
  import pwm_tmr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CH_PER_BANK = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busValid,
  input  logic                             busWrite,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [REG_W-1:0]                 busWdata,
  output logic [REG_W-1:0]                 busRdata,
  output logic                             busRvalid,
  input  logic                             extClk,
  output logic [BANKS*CH_PER_BANK-1:0]     pwmOut,
  output logic [BANKS*CH_PER_BANK-1:0]     pwmOe,
  output logic [BANKS*CH_PER_BANK-1:0]     irq
);
  localparam int NUM_CH = BANKS * CH_PER_BANK;

  chanStb_t                     chStb [NUM_CH];
  logic [NUM_CH-1:0][REG_W-1:0] chCount, chHigh, chLow, chCtrl;

  pwm_tmr_ctrl #(.ADDR_W(ADDR_W), .CH_PER_BANK(CH_PER_BANK), .NUM_CH(NUM_CH)) i_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .extClk(extClk),
    .chCount(chCount), .chHigh(chHigh), .chLow(chLow), .chCtrl(chCtrl),
    .chStb(chStb), .busRdata(busRdata), .busRvalid(busRvalid)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_tmr_chan i_chan (
      .clk(clk), .rstN(rstN), .stb(chStb[c]), .wdata(busWdata),
      .countVal(chCount[c]), .highVal(chHigh[c]), .lowVal(chLow[c]), .ctrlVal(chCtrl[c]),
      .pwmOut(pwmOut[c]), .pwmOe(pwmOe[c]), .irq(irq[c])
    );
  end
endmodule

// File: tb/test_pwm_tmr_top.sv
`timescale 1ns/1ps
module test_pwm_tmr_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic        extClk = 1'b0;
  logic [7:0]  pwmOut, pwmOe, irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwm_tmr_top i_pwm_tmr_top (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busRvalid(busRvalid),
    .extClk(extClk), .pwmOut(pwmOut), .pwmOe(pwmOe), .irq(irq)
  );

  // columns: channel, duty threshold, period limit, ticks, expected pwmOut,
  // expected counter after stop edge, expected pending
  localparam int VEC [8][7] = '{
    '{0, 3, 10, 2, 0, 3, 0},
    '{0, 3, 10, 5, 1, 6, 0},
    '{5, 4,  6, 9, 0, 4, 1},
    '{7, 8,  5, 7, 0, 3, 1},
    '{3, 0,  4, 1, 1, 2, 0},
    '{2, 2,  0, 3, 0, 0, 1},
    '{4, 1,  3, 5, 1, 0, 1},
    '{6, 5,  7, 6, 1, 0, 1}
  };

  function automatic logic [15:0] chBase(int ch);
    return 16'((ch >= 4 ? 32'h8000 : 32'h0) + (ch % 4) * 16);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic busWr(logic [15:0] a, logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(logic [15:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
    total++;
    if (busRvalid !== 1'b1) begin
      bad++;
      $display("FAIL R1 rvalid: got %0b expected 1", busRvalid);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // reset state
    check("R5 reset pwmOe", {24'b0, pwmOe}, 32'h0);
    check("R8 reset irq", {24'b0, irq}, 32'h0);
    check("R1 reset rvalid", {31'b0, busRvalid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    busRd(16'h000C, rd); check("R2 reset ctrl", rd, 32'h0);

    // R1 hole bits ignored
    busWr(16'h0040, 32'h1234);
    busRd(16'h0000, rd); check("R1 hole write ignored", rd, 32'h0);
    busRd(16'h0040, rd); check("R1 hole read zero", rd, 32'h0);
    // R1/R12 bank select and independence
    busWr(16'h8004, 32'hAB);
    busRd(16'h8004, rd); check("R1 bank1 ch4 high", rd, 32'hAB);
    busRd(16'h0004, rd); check("R12 ch0 high untouched", rd, 32'h0);
    // R2 control readback
    busWr(16'h000C, 32'h13E);
    busRd(16'h000C, rd); check("R2 ctrl readback", rd, 32'h13E);
    check("R5 drive bit to pwmOe", {31'b0, pwmOe[0]}, 32'h1);
    busWr(16'h000C, 32'h0);

    // table walk
    for (int v = 0; v < 8; v++) begin
      int ch;
      logic [15:0] b;
      ch = VEC[v][0];
      b = chBase(ch);
      busWr(b + 16'h8, 32'(VEC[v][2]));
      busWr(b + 16'h4, 32'(VEC[v][1]));
      busWr(b, 32'h0);
      busWr(b + 16'hC, 32'h9);
      repeat (VEC[v][3]) @(negedge clk);
      check($sformatf("R4 vec%0d pwmOut", v), {31'b0, pwmOut[ch]}, 32'(VEC[v][4]));
      check($sformatf("R5 vec%0d pwmOe on", v), {31'b0, pwmOe[ch]}, 32'h1);
      busWr(b + 16'hC, 32'h0);
      check($sformatf("R5 vec%0d pwmOe off", v), {31'b0, pwmOe[ch]}, 32'h0);
      busRd(b, rd); check($sformatf("R3 vec%0d counter", v), rd, 32'(VEC[v][5]));
      busRd(b, rd); check($sformatf("R6 vec%0d counter held", v), rd, 32'(VEC[v][5]));
      busRd(b + 16'hC, rd); check($sformatf("R8 vec%0d pending", v), rd, 32'(VEC[v][6] << 6));
      busWr(b + 16'hC, 32'h40);
    end

    // R8 interrupt on channel 1
    busWr(16'h0018, 32'd3);
    busWr(16'h0014, 32'd1);
    busWr(16'h0010, 32'd0);
    busWr(16'h001C, 32'h21);
    repeat (2) @(negedge clk);
    check("R8 irq before wrap", {31'b0, irq[1]}, 32'h0);
    @(negedge clk);
    check("R8 irq at wrap", {31'b0, irq[1]}, 32'h1);
    busWr(16'h001C, 32'h20);
    check("R8 write 0 keeps pending", {31'b0, irq[1]}, 32'h1);
    busWr(16'h001C, 32'h60);
    check("R8 write 1 clears", {31'b0, irq[1]}, 32'h0);

    // R9 single period on channel 2
    busWr(16'h0028, 32'd4);
    busWr(16'h0024, 32'd2);
    busWr(16'h0020, 32'd0);
    busWr(16'h002C, 32'h11);
    repeat (10) @(negedge clk);
    busRd(16'h002C, rd); check("R9 run cleared", rd, 32'h50);
    busRd(16'h0020, rd); check("R9 counter at 0", rd, 32'h0);

    // R10 counter clear on channel 3
    busWr(16'h0030, 32'h55);
    busWr(16'h003C, 32'h80);
    @(negedge clk);
    busRd(16'h0030, rd); check("R10 counter cleared", rd, 32'h0);
    busRd(16'h003C, rd); check("R10 bit self-clears", rd, 32'h0);

    // R7 counter write while running on channel 6
    busWr(16'h8028, 32'd100);
    busWr(16'h8024, 32'd50);
    busWr(16'h8020, 32'd0);
    busWr(16'h802C, 32'h1);
    repeat (3) @(negedge clk);
    busWr(16'h8020, 32'd40);
    check("R7 loaded below threshold", {31'b0, pwmOut[6]}, 32'h0);
    repeat (10) @(negedge clk);
    check("R7 counting from loaded value", {31'b0, pwmOut[6]}, 32'h1);
    busWr(16'h802C, 32'h0);

    // R11 external ticks on channel 7
    busWr(16'h8038, 32'd100);
    busWr(16'h8030, 32'd0);
    busWr(16'h803C, 32'h3);
    for (int i = 0; i < 5; i++) begin
      extClk = 1'b1; repeat (4) @(negedge clk);
      extClk = 1'b0; repeat (4) @(negedge clk);
    end
    busRd(16'h8030, rd); check("R11 rising edges", rd, 32'd5);
    busWr(16'h803C, 32'h7);
    busWr(16'h8030, 32'd0);
    extClk = 1'b1; repeat (6) @(negedge clk);
    busRd(16'h8030, rd); check("R11 rise ignored in falling mode", rd, 32'd0);
    extClk = 1'b0; repeat (6) @(negedge clk);
    busRd(16'h8030, rd); check("R11 falling edge counts", rd, 32'd1);
    busWr(16'h803C, 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule